// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block sits behind the command decoder of a serial flash. It decides, for each command frame, whether that command may run. At the moment chip select is released, the decoder presents the opcode, the target address, the number of serial clock pulses in the frame and, for a status write, the data byte. One cycle later the gate answers with exactly one strobe: accept or reject. The gate holds all protection state: the write-enable latch, two region-protect bits, a status-lock bit, a write-in-progress flag and a deep-sleep flag. It presents this state as a status byte.

Program and erase timing belong to an external operation engine. An accepted program, erase or status write raises write-in-progress. A done pulse from the engine clears that flag and the write-enable latch. The external write-protect pin (active low) works together with the status-lock bit to freeze the status register. While the part sleeps, every command except wake is refused.

Top module: `flash_wprot_gate`

## Requirements
- R1: Page program (0x02), sector erase (0xD8), bulk erase (0xC7) and status write (0x01) are accepted only when the frame clock count is an exact multiple of eight (count[2:0] == 0). Other commands do not check the count.
- R2: The four commands of R1 are rejected unless the write-enable latch is set. Write enable (0x06) sets the latch and write disable (0x04) clears it; both are accepted whatever the frame length.
- R3: The write-enable latch is 0 after reset. It clears on the done pulse that ends an accepted program, erase or status write.
- R4: Address bits [16:15] select one of four 32 KiB sectors. The region-protect bits bp protect sectors as follows: 00 protects none, 01 protects sector 3, 10 protects sectors 2–3, 11 protects all sectors. Program or sector erase aimed at a protected sector is rejected.
- R5: Bulk erase is accepted only when both region-protect bits are 0.
- R6: An accepted status write loads data bit 7 into the status-lock bit and data bits 3:2 into the region-protect bits. When the status-lock bit is 1 and the write-protect pin is low, a status write is rejected and both fields stay frozen.
- R7: Sleep (0xB9) enters deep power-down and wake (0xAB) leaves it. While asleep, every command other than wake is rejected and has no effect.
- R8: Write-in-progress is set by the accept of any R1 command and cleared only by the done pulse. While it is set, only status read (0x05) is accepted.
- R9: The status byte is {lock, 3'b000, bp[1:0], latch, write-in-progress}. It is 0x00 after reset.
- R10: Every command strobe produces exactly one of accept or reject, one clock cycle later. An opcode not listed here is rejected.
- R11: A rejected command changes no state. In particular, a write-enable latch that was set stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| cmd_valid | input | 1 | One-cycle strobe at chip-select release |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | 17 | Target byte address |
| cmd_bits | input | 12 | Serial clock pulses counted in the frame |
| cmd_wdata | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Operation engine finished pulse |
| acc_o | output | 1 | Command accepted strobe |
| rej_o | output | 1 | Command rejected strobe |
| status_o | output | 8 | Status byte |

## Verification
Some properties are checked on every cycle by assertions. A command strobe always yields exactly one answer. A rejected command never moves the latch. Write-in-progress falls only on a done pulse. A locked status register holds its protect fields. Bulk erase is never granted with protection set. Nothing but wake is granted while asleep. Other behaviour only the bench scenarios can show: the exact sector map for each protect setting, the frame-length screen, the status-byte layout after status writes, and the sequence sleep, refused commands, wake, with the latch still clear afterwards.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

  localparam logic [7:0] OPC_WR_EN      = 8'h06;
  localparam logic [7:0] OPC_WR_DIS     = 8'h04;
  localparam logic [7:0] OPC_STAT_WR    = 8'h01;
  localparam logic [7:0] OPC_STAT_RD    = 8'h05;
  localparam logic [7:0] OPC_PAGE_PGM   = 8'h02;
  localparam logic [7:0] OPC_SEC_ERASE  = 8'hD8;
  localparam logic [7:0] OPC_CHIP_ERASE = 8'hC7;
  localparam logic [7:0] OPC_SLEEP      = 8'hB9;
  localparam logic [7:0] OPC_WAKE       = 8'hAB;

  typedef enum logic [3:0] {
    K_NONE, K_WEN, K_WDIS, K_SWR, K_SRD, K_PGM, K_SER, K_CER, K_SLEEP, K_WAKE
  } cmd_kind_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] bp;
    logic       wel;
    logic       wip;
    logic       sleep;
  } prot_st_t;

  function automatic cmd_kind_e classify(input logic [7:0] op);
    case (op)
      OPC_WR_EN:      return K_WEN;
      OPC_WR_DIS:     return K_WDIS;
      OPC_STAT_WR:    return K_SWR;
      OPC_STAT_RD:    return K_SRD;
      OPC_PAGE_PGM:   return K_PGM;
      OPC_SEC_ERASE:  return K_SER;
      OPC_CHIP_ERASE: return K_CER;
      OPC_SLEEP:      return K_SLEEP;
      OPC_WAKE:       return K_WAKE;
      default:        return K_NONE;
    endcase
  endfunction

  function automatic logic is_modifying(input cmd_kind_e k);
    return (k == K_SWR) || (k == K_PGM) || (k == K_SER) || (k == K_CER);
  endfunction

  function automatic logic frame_whole(input logic [2:0] cnt_lsb);
    return cnt_lsb == 3'b000;
  endfunction

  // Protected sectors are the top (nsec >> (3-bp)) sectors; bp==0 protects none.
  function automatic logic sector_locked(input logic [1:0] bp,
                                         input int unsigned sec,
                                         input int unsigned nsec);
    int unsigned cnt;
    if (bp == 2'b00) return 1'b0;
    cnt = nsec >> (3 - int'(bp));
    return sec >= (nsec - cnt);
  endfunction

  function automatic logic [7:0] pack_status(input prot_st_t s);
    return {s.lock, 3'b000, s.bp, s.wel, s.wip};
  endfunction

endpackage

// File: rtl/fwp_decide.sv
module fwp_decide
  import fwp_pkg::*;
#(
  parameter int SEC_W = 2,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  prot_st_t         st,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [SEC_W-1:0] cmd_sec,
  input  logic [CNT_W-1:0] cmd_bits,
  input  logic             wp_n,
  output cmd_kind_e        kind,
  output logic             grant,
  output logic             deny,
  output logic             hpm_lock
);
  localparam int unsigned NSEC = 1 << SEC_W;

  logic whole;
  logic locked;
  logic ok;
  logic unused_bits;

  assign unused_bits = ^cmd_bits[CNT_W-1:3];
  assign kind     = classify(cmd_op);
  assign whole    = frame_whole(cmd_bits[2:0]);
  assign locked   = sector_locked(st.bp, int'(cmd_sec), NSEC);
  assign hpm_lock = st.lock & ~wp_n;

  always_comb begin
    ok = 1'b0;
    if (st.sleep) begin
      ok = (kind == K_WAKE);
    end else if (st.wip) begin
      ok = (kind == K_SRD);
    end else begin
      case (kind)
        K_WEN, K_WDIS, K_SRD, K_SLEEP, K_WAKE: ok = 1'b1;
        K_SWR:        ok = whole & st.wel & ~hpm_lock;
        K_PGM, K_SER: ok = whole & st.wel & ~locked;
        K_CER:        ok = whole & st.wel & (st.bp == 2'b00);
        default:      ok = 1'b0;
      endcase
    end
  end

  assign grant = cmd_valid & ok;
  assign deny  = cmd_valid & ~ok;

  assert_bulk_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && kind == K_CER) |-> (st.bp == 2'b00));
  assert_sleep_wake_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && st.sleep) |-> (kind == K_WAKE));
  assert_busy_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && st.wip) |-> (kind == K_SRD));
  assert_frame_whole_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && is_modifying(kind)) |-> (cmd_bits[2:0] == 3'b000 && st.wel));

endmodule

// File: rtl/fwp_regs.sv
module fwp_regs
  import fwp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      grant,
  input  cmd_kind_e kind,
  input  logic [7:0] wr_data,
  input  logic      op_done,
  input  logic      hpm_lock,
  output prot_st_t  st_q
);
  logic unused_data;
  logic finish_evt;

  assign unused_data = ^{wr_data[6:4], wr_data[1:0]};
  assign finish_evt  = op_done & st_q.wip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      if (finish_evt) begin
        st_q.wip <= 1'b0;
        st_q.wel <= 1'b0;
      end
      if (grant) begin
        case (kind)
          K_WEN:   st_q.wel <= 1'b1;
          K_WDIS:  st_q.wel <= 1'b0;
          K_SWR: begin
            st_q.lock <= wr_data[7];
            st_q.bp   <= wr_data[3:2];
            st_q.wip  <= 1'b1;
          end
          K_PGM, K_SER, K_CER: st_q.wip <= 1'b1;
          K_SLEEP: st_q.sleep <= 1'b1;
          K_WAKE:  st_q.sleep <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assert_wip_fall_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q.wip) |-> $past(op_done));
  assert_hpm_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hpm_lock |=> ($stable(st_q.bp) && $stable(st_q.lock)));
  assert_wel_clear_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q.wel) |-> ($past(op_done) || $past(grant && kind == K_WDIS)));

endmodule

// File: rtl/flash_wprot_gate.sv
module flash_wprot_gate
  import fwp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int SEC_W  = 2,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_bits,
  input  logic [7:0]        cmd_wdata,
  input  logic              wp_n,
  input  logic              op_done,
  output logic              acc_o,
  output logic              rej_o,
  output logic [7:0]        status_o
);
  localparam int OFS_W = ADDR_W - SEC_W;

  prot_st_t   st;
  cmd_kind_e  kind;
  logic       grant;
  logic       deny;
  logic       hpm_lock;
  logic [SEC_W-1:0] sec;
  logic       unused_addr;

  assign sec         = cmd_addr[ADDR_W-1:OFS_W];
  assign unused_addr = ^cmd_addr[OFS_W-1:0];

  fwp_decide #(.SEC_W(SEC_W), .CNT_W(CNT_W)) decide_i (
    .clk(clk), .rst_n(rst_n), .st(st), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_sec(sec), .cmd_bits(cmd_bits), .wp_n(wp_n),
    .kind(kind), .grant(grant), .deny(deny), .hpm_lock(hpm_lock)
  );

  fwp_regs regs_i (
    .clk(clk), .rst_n(rst_n), .grant(grant), .kind(kind),
    .wr_data(cmd_wdata), .op_done(op_done), .hpm_lock(hpm_lock), .st_q(st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o <= 1'b0;
      rej_o <= 1'b0;
    end else begin
      acc_o <= grant;
      rej_o <= deny;
    end
  end

  assign status_o = pack_status(st);

  assert_one_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (acc_o ^ rej_o));
  assert_no_idle_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !(acc_o || rej_o));
  assert_reject_keeps_wel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_o && !$past(op_done)) |-> (status_o[1] == $past(status_o[1])));

endmodule

// File: tb/flash_wprot_gate_tb.sv
module flash_wprot_gate_tb_top;

  typedef struct {
    bit         acc;
    logic [7:0] stat;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic [16:0] cmd_addr = '0;
  logic [11:0] cmd_bits = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        wp_n = 1'b1;
  logic        op_done = 1'b0;
  logic        acc_o, rej_o;
  logic [7:0]  status_o;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];
  logic mon_armed = 1'b0;

  // reference state
  bit       m_wel, m_wip, m_lock, m_sleep;
  bit [1:0] m_bp;

  always #5 clk = ~clk;

  flash_wprot_gate dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_bits(cmd_bits), .cmd_wdata(cmd_wdata),
    .wp_n(wp_n), .op_done(op_done), .acc_o(acc_o), .rej_o(rej_o),
    .status_o(status_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_status();
    return {m_lock, 3'b000, m_bp, m_wel, m_wip};
  endfunction

  function automatic bit ref_prot(input bit [1:0] bp, input bit [16:0] a);
    int s;
    s = a / 32768;
    if (bp == 2'd1) return s == 3;
    if (bp == 2'd2) return s >= 2;
    return bp == 2'd3;
  endfunction

  task automatic issue(input logic [7:0] op, input logic [16:0] a,
                       input int nbits, input logic [7:0] d, input string tag);
    bit ok;
    bit writes;
    exp_t e;
    writes = (op == 8'h02) || (op == 8'hD8) || (op == 8'hC7) || (op == 8'h01);
    if (m_sleep) ok = (op == 8'hAB);
    else if (m_wip) ok = (op == 8'h05);
    else if (writes) begin
      ok = (nbits % 8 == 0) && m_wel;
      if (op == 8'h01 && m_lock && !wp_n) ok = 0;
      if ((op == 8'h02 || op == 8'hD8) && ref_prot(m_bp, a)) ok = 0;
      if (op == 8'hC7 && m_bp != 0) ok = 0;
    end else
      ok = (op == 8'h06) || (op == 8'h04) || (op == 8'h05) ||
           (op == 8'hB9) || (op == 8'hAB);
    if (ok) begin
      if (op == 8'h06) m_wel = 1;
      if (op == 8'h04) m_wel = 0;
      if (op == 8'hB9) m_sleep = 1;
      if (op == 8'hAB) m_sleep = 0;
      if (op == 8'h01) begin m_lock = d[7]; m_bp = d[3:2]; end
      if (writes) m_wip = 1;
    end
    e.acc = ok; e.stat = ref_status(); e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_bits = 12'(nbits); cmd_wdata = d;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    op_done = 1'b1;
    if (m_wip) begin m_wip = 0; m_wel = 0; end
    @(negedge clk);
    op_done = 1'b0;
  endtask

  always @(posedge clk) mon_armed <= cmd_valid;

  always @(negedge clk) begin
    if (mon_armed) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected answer", 0, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(acc_o == e.acc && rej_o == !e.acc, {e.tag, " strobe"},
            {acc_o, rej_o}, {e.acc, !e.acc});
        chk(status_o == e.stat, {e.tag, " status"}, status_o, e.stat);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_wel = 0; m_wip = 0; m_lock = 0; m_sleep = 0; m_bp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status_o == 8'h00, "R9 R3 reset status", status_o, 0);
    chk(!acc_o && !rej_o, "R10 reset strobes", {acc_o, rej_o}, 0);

    issue(8'h02, 17'h00100, 40, 0, "R2 program without latch");
    issue(8'h9F, 17'h0, 8, 0, "R10 unknown opcode");
    issue(8'h06, 17'h0, 8, 0, "R2 write enable");
    issue(8'h02, 17'h00100, 36, 0, "R1 odd frame program");
    issue(8'h01, 17'h0, 12, 8'h0C, "R1 odd frame status write");
    issue(8'h02, 17'h00100, 40, 0, "R1 whole frame program");
    issue(8'h05, 17'h0, 16, 0, "R8 status read while busy");
    issue(8'h06, 17'h0, 8, 0, "R8 enable while busy");
    finish_op();
    issue(8'h05, 17'h0, 16, 0, "R3 latch cleared by done");

    issue(8'h06, 17'h0, 8, 0, "R2 enable");
    issue(8'h01, 17'h0, 16, 8'h84, "R6 status write lock bp01");
    finish_op();
    issue(8'h06, 17'h0, 8, 0, "R2 enable");
    issue(8'h02, 17'h18000, 40, 0, "R4 bp01 sector3 program");
    issue(8'hD8, 17'h18000, 32, 0, "R11 latch kept after reject");
    issue(8'hC7, 17'h0, 8, 0, "R5 bulk erase with protection");
    issue(8'hD8, 17'h10000, 32, 0, "R4 bp01 sector2 erase");
    finish_op();

    issue(8'h06, 17'h0, 8, 0, "R2 enable");
    wp_n = 1'b0;
    issue(8'h01, 17'h0, 16, 8'h00, "R6 locked status write");
    issue(8'h05, 17'h0, 16, 0, "R6 fields frozen");
    wp_n = 1'b1;
    issue(8'h01, 17'h0, 16, 8'h08, "R6 unlocked pin bp10");
    finish_op();
    issue(8'h06, 17'h0, 8, 0, "R2 enable");
    issue(8'h02, 17'h10000, 40, 0, "R4 bp10 sector2 program");
    issue(8'h02, 17'h08000, 40, 0, "R4 bp10 sector1 program");
    finish_op();
    issue(8'h06, 17'h0, 8, 0, "R2 enable");
    wp_n = 1'b0;
    issue(8'h01, 17'h0, 16, 8'h0C, "R6 pin low lock clear bp11");
    wp_n = 1'b1;
    finish_op();
    issue(8'h06, 17'h0, 8, 0, "R2 enable");
    issue(8'hD8, 17'h00000, 32, 0, "R4 bp11 sector0 erase");
    issue(8'h01, 17'h0, 16, 8'h00, "R6 clear protection");
    finish_op();
    issue(8'h06, 17'h0, 8, 0, "R2 enable");
    issue(8'hC7, 17'h0, 12, 0, "R1 odd frame bulk erase");
    issue(8'hC7, 17'h0, 8, 0, "R5 bulk erase unprotected");
    finish_op();
    issue(8'h06, 17'h0, 8, 0, "R2 enable");
    issue(8'h04, 17'h0, 8, 0, "R2 write disable");

    issue(8'hB9, 17'h0, 8, 0, "R7 sleep");
    issue(8'h06, 17'h0, 8, 0, "R7 enable while asleep");
    issue(8'h05, 17'h0, 16, 0, "R7 status read while asleep");
    issue(8'hAB, 17'h0, 8, 0, "R7 wake");
    issue(8'h05, 17'h0, 16, 0, "R7 latch untouched by sleep");
    issue(8'hAB, 17'h0, 8, 0, "R7 wake while awake");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all answered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule